// File: doc/BRIEF.md
# Module Identification EEPROM with Two-Wire Slave

This block models a 256-byte identification memory on a memory module, read and written by a host over the two-wire (I2C) serial bus. The host addresses the device, sets a byte pointer, and then writes one or more bytes or reads any number of bytes. During a read the pointer advances on its own. Three board strap pins complete the device's bus address, so that up to eight modules can share one bus.

Bytes 0 to 63 come out of reset holding a fixed configuration image. The last byte of that image is a checksum over the bytes before it. A lock input protects the lower 128 bytes from writes, while the upper 128 bytes stay free for the user. A self-check output reports continuously whether the stored checksum still matches the bytes it covers.

The bus signals are oversampled on the system clock. SDA is open-drain: the block only ever pulls the line low or releases it.

Top module: `spd_eeprom`

## Requirements
- R1: After reset, bytes 0 to 4 read back as 0x80, 0x08, 0x07, 0x0D and 0x0B.
- R2: The device acknowledges a first byte whose upper seven bits are binary 1010 followed by strap_i[2:0], with bit 0 as read (1) or write (0). Any other address gets no acknowledge, and SDA stays released.
- R3: A write transfer is device address, then byte pointer, then data bytes. Each byte is acknowledged. A byte written to an address of 128 or above is stored and reads back unchanged.
- R4: While lock_i is high, a write to an address below 128 is acknowledged but not stored. While lock_i is low, such a write is stored.
- R5: A random read works as follows: write the device address and the byte pointer, issue a repeated START, then send the device address with the read bit set. The first byte returned is the one at the pointer.
- R6: In a sequential read the pointer advances by one after every byte, and it wraps from 255 to 0. The read ends when the host does not acknowledge.
- R7: Byte 63 of the reset image equals the low 8 bits of the sum of bytes 0 to 62. csum_err_o is low exactly while this relation holds in the stored contents.
- R8: A STOP (SDA rising while SCL is high) at any point, including in the middle of a byte, returns the slave to idle with SDA released. The next transfer then works normally.
- R9: The slave never changes its SDA drive while SCL is high. A START or a STOP always leaves SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low; loads the default image |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Sensed level of the shared SDA line |
| sda_oe_o | output | 1 | When high, pulls SDA low |
| strap_i | input | 3 | Board straps; the low three bits of the device address |
| lock_i | input | 1 | When high, write-protects bytes 0 to 127 |
| csum_err_o | output | 1 | High when byte 63 does not match the sum of bytes 0 to 62 |

## Verification
Most errors in the protocol state machine show up in the acknowledge bit of the same byte. A wrong bit count or a wrong address decision shows up as a missing or spurious acknowledge. A pointer fault first shows up as a wrong data byte on the following read, several hundred clocks later. Wrong storage gating shows up on the next read of that address, or as csum_err_o changing one clock after the write. For these reasons every write is followed by a read-back, and csum_err_o is sampled right after each write to the lower half.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_ADR, ST_ADR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } spd_state_e;

  // configuration image content, unlisted bytes are zero
  function automatic logic [7:0] img_byte(int unsigned idx);
    case (idx)
      0:  return 8'h80;
      1:  return 8'h08;
      2:  return 8'h07;
      3:  return 8'h0D;
      4:  return 8'h0B;
      5:  return 8'h02;
      6:  return 8'h48;
      11: return 8'h02;
      12: return 8'h82;
      13: return 8'h04;
      16: return 8'h0E;
      17: return 8'h04;
      18: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  // reset value of a byte; the last image byte is the checksum of the rest
  function automatic logic [7:0] img_init(int unsigned idx, int unsigned img);
    logic [7:0] acc;
    acc = 8'h00;
    if (idx >= img) return 8'h00;
    if (idx == img - 1) begin
      for (int unsigned i = 0; i < img - 1; i++) acc = acc + img_byte(i);
      return acc;
    end
    return img_byte(idx);
  endfunction

endpackage

// File: rtl/spd_bus_sync.sv
module spd_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
      scl_d_q    <= scl_o;
      sda_d_q    <= sda_o;
    end
  end

  assign scl_o      = scl_sync_q[SYNC_STAGES-1];
  assign sda_o      = sda_sync_q[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d_q;
  assign scl_fall_o = ~scl_o & scl_d_q;
  assign start_o    = scl_o & scl_d_q & sda_d_q & ~sda_o;
  assign stop_o     = scl_o & scl_d_q & ~sda_d_q & sda_o;
endmodule

// File: rtl/spd_store.sv
module spd_store
  import spd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IMG_BYTES  = 64,
  parameter int unsigned LOCK_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic              lock_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output logic              csum_err_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem_q [DEPTH];
  logic       wr_ok;
  logic [7:0] acc;

  assign wr_ok = we_i && !(lock_i && (int'(waddr_i) < LOCK_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= img_init(i, IMG_BYTES);
    end else if (wr_ok) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  always_comb begin
    acc = 8'h00;
    for (int i = 0; i < IMG_BYTES - 1; i++) acc = acc + mem_q[i];
  end

  assign csum_err_o = (acc != mem_q[IMG_BYTES-1]);
endmodule

// File: rtl/spd_slave_fsm.sv
module spd_slave_fsm
  import spd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic              sda_oe_o
);
  spd_state_e        state_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rd_q, nack_q;
  logic              rx_state;

  assign rx_state = (state_q == ST_DEV) || (state_q == ST_ADR) || (state_q == ST_WR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      nack_q  <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
      end else if (start_i) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
      end else if (rx_state) begin
        if (scl_rise_i) begin
          sh_q  <= {sh_q[6:0], sda_s_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          unique case (state_q)
            ST_DEV: begin
              if (sh_q[7:1] == {DEV_CODE, strap_i}) begin
                rd_q    <= sh_q[0];
                state_q <= ST_DEV_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
            ST_ADR: begin
              ptr_q   <= sh_q[ADDR_W-1:0];
              state_q <= ST_ADR_ACK;
            end
            default: begin
              we_o    <= 1'b1;
              waddr_o <= ptr_q;
              wdata_o <= sh_q;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_WR_ACK;
            end
          endcase
        end
      end else begin
        unique case (state_q)
          ST_DEV_ACK, ST_ADR_ACK, ST_WR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (state_q == ST_DEV_ACK && rd_q) begin
              sh_q    <= rdata_i;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RD;
            end else begin
              state_q <= (state_q == ST_DEV_ACK) ? ST_ADR : ST_WR;
            end
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              state_q <= ST_RD_ACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) nack_q <= sda_s_i;
            if (scl_fall_i) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                sh_q    <= rdata_i;
                ptr_q   <= ptr_q + 1'b1;
                cnt_q   <= '0;
                state_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign sda_oe_o = (state_q == ST_DEV_ACK) || (state_q == ST_ADR_ACK) ||
                    (state_q == ST_WR_ACK) || (state_q == ST_RD && !sh_q[7]);
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IMG_BYTES   = 64,
  parameter int unsigned LOCK_BYTES  = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       lock_i,
  output logic       csum_err_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic we;
  logic [ADDR_W-1:0] ptr, waddr;
  logic [7:0] wdata, rdata;

  spd_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  spd_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .strap_i, .rdata_i(rdata),
    .ptr_o(ptr), .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .sda_oe_o
  );

  spd_store #(.ADDR_W(ADDR_W), .IMG_BYTES(IMG_BYTES), .LOCK_BYTES(LOCK_BYTES)) u_store (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .lock_i,
    .raddr_i(ptr), .rdata_o(rdata), .csum_err_o
  );
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_i,
  input logic scl_s,
  input logic start_evt,
  input logic stop_evt,
  input logic sda_oe_o,
  input logic csum_err_o
);
  a_r8_stop_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_oe_o);

  a_r9_start_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> !sda_oe_o);

  a_r9_change_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  a_r4_locked_csum_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(csum_err_o));

  a_r9_no_stop_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> !stop_evt);
endmodule

bind spd_eeprom spd_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .scl_s(scl_s),
  .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe_o(sda_oe_o), .csum_err_o(csum_err_o)
);

// File: tb/spd_eeprom_tb.sv
module spd_eeprom_tb;
  localparam time Q = 120ns;
  localparam int WD_LIMIT = 190000;
  localparam logic [7:0] DEV_W = 8'hAA;  // 1010 + strap 101 + write
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic lock = 1'b1;
  logic dut_oe, csum_err, sda_w;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0, sb_en = 1;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  logic [7:0] rbuf [64];

  always #10ns clk = ~clk;
  assign sda_w = ~(m_low | dut_oe);

  spd_eeprom u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_w), .sda_oe_o(dut_oe),
    .strap_i(strap), .lock_i(lock), .csum_err_o(csum_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      check(0, "watchdog", cyc, WD_LIMIT);
      summary();
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() != 0 && exp_q.size() != 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(a == e, t, a, e);
    end
  end

  task automatic expect_byte(input string t, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; #(Q); scl = 1'b1; #(2*Q); scl = 1'b0; #(Q);
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; #(Q); scl = 1'b1; #(Q); b = sda_w; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; #(Q); scl = 1'b1; #(Q); m_low = 1'b1; #(Q); scl = 1'b0; #(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; #(Q); scl = 1'b1; #(Q); m_low = 1'b0; #(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(last);
  endtask

  task automatic wr_bytes(input string t, input logic [7:0] addr, input logic [7:0] d0,
                          input logic [7:0] d1, input int n);
    logic a;
    i2c_start();
    send_byte(DEV_W, a); check(a, {t, " dev ack"}, a, 1);
    send_byte(addr, a);  check(a, {t, " ptr ack"}, a, 1);
    send_byte(d0, a);    check(a, {t, " data ack"}, a, 1);
    if (n > 1) begin
      send_byte(d1, a);  check(a, {t, " data2 ack"}, a, 1);
    end
    i2c_stop();
  endtask

  // random read of n bytes from addr (R5), bytes go to rbuf and the scoreboard
  task automatic rd_bytes(input string t, input logic [7:0] addr, input int n);
    logic a;
    logic [7:0] v;
    i2c_start();
    send_byte(DEV_W, a); check(a, {t, " dev ack"}, a, 1);
    send_byte(addr, a);  check(a, {t, " ptr ack"}, a, 1);
    i2c_start();
    send_byte(DEV_R, a); check(a, {t, " rd ack"}, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, v);
      rbuf[i] = v;
      if (sb_en) act_q.push_back(v);
    end
    i2c_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] sum;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(dut_oe == 1'b0, "R9 reset release", dut_oe, 0);
    check(csum_err == 1'b0, "R7 reset csum", csum_err, 0);

    // R1 + R5: image bytes via random read
    expect_byte("R1 byte0", 8'h80); expect_byte("R1 byte1", 8'h08);
    expect_byte("R1 byte2", 8'h07); expect_byte("R1 byte3", 8'h0D);
    expect_byte("R1 byte4", 8'h0B);
    rd_bytes("R5", 8'h00, 5);

    // R7: checksum relation over the reset image
    sb_en = 0;
    rd_bytes("R7", 8'h00, 64);
    sb_en = 1;
    sum = 8'h00;
    for (int i = 0; i < 63; i++) sum = sum + rbuf[i];
    check(sum == rbuf[63], "R7 byte63 sum", rbuf[63], sum);

    // R2: wrong addresses get no acknowledge
    i2c_start(); send_byte(8'hA0, a); check(!a && !dut_oe, "R2 strap mismatch nack", a, 0); i2c_stop();
    i2c_start(); send_byte(8'hBA, a); check(!a, "R2 code mismatch nack", a, 0); i2c_stop();
    strap = 3'b010;
    i2c_start(); send_byte(8'hA4, a); check(a, "R2 new strap ack", a, 1); i2c_stop();
    strap = 3'b101;

    // R3: upper half write and readback
    wr_bytes("R3", 8'h90, 8'h5A, 8'h00, 1);
    expect_byte("R3 readback", 8'h5A);
    rd_bytes("R3", 8'h90, 1);

    // R4: locked lower write ignored
    wr_bytes("R4", 8'h03, 8'h55, 8'h00, 1);
    repeat (2) @(negedge clk);
    check(csum_err == 1'b0, "R4 locked csum", csum_err, 0);
    expect_byte("R4 locked byte3", 8'h0D);
    rd_bytes("R4", 8'h03, 1);

    // R4 + R7: unlocked write stored, checksum flag follows
    lock = 1'b0;
    wr_bytes("R4", 8'h03, 8'h0E, 8'h00, 1);
    repeat (2) @(negedge clk);
    check(csum_err == 1'b1, "R7 mismatch flagged", csum_err, 1);
    expect_byte("R4 unlocked byte3", 8'h0E);
    rd_bytes("R4", 8'h03, 1);
    wr_bytes("R7", 8'h03, 8'h0D, 8'h00, 1);
    repeat (2) @(negedge clk);
    check(csum_err == 1'b0, "R7 restored", csum_err, 0);
    lock = 1'b1;

    // R6: sequential read wraps 255 -> 0
    wr_bytes("R6", 8'hFE, 8'h3C, 8'hC3, 2);
    expect_byte("R6 fe", 8'h3C); expect_byte("R6 ff", 8'hC3);
    expect_byte("R6 wrap 00", 8'h80); expect_byte("R6 wrap 01", 8'h08);
    rd_bytes("R6", 8'hFE, 4);

    // R8: STOP in the middle of the pointer byte
    i2c_start();
    send_byte(DEV_W, a); check(a, "R8 dev ack", a, 1);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    i2c_stop();
    check(dut_oe == 1'b0, "R8 released", dut_oe, 0);
    expect_byte("R8 after abort", 8'h5A);
    rd_bytes("R8", 8'h90, 1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "SB drained", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule